// File: doc/BRIEF.md
# Segmented Flash Array Address Generator

This block produces the 26-bit byte address into a 512Mb serial flash array. At the start of each command it takes the address the command carried. In 4-byte mode it uses the low 26 bits of that address directly. In 3-byte mode it forms the address from the low 24 command bits, with the top two bits taken from a small segment register. That register picks one of four 128Mb segments.

During a continuous read, each byte-advance strobe moves the address on by one. The count runs across segment boundaries and rolls from the last array byte back to zero, so one read can stream the whole array. The segment register is never changed by such a crossing. Software writes the segment register through a byte-wide port, and it always reads back with the six upper bits at zero. When reset is applied, its value is taken from a default-select pin: segment 0 when the pin is low, segment 3 when it is high.

A two-state sequencer gates the advance. In state `ST_IDLE` no address has been loaded yet, and advance strobes are ignored. The transition `ST_IDLE -> ST_STREAM` occurs on the first load strobe. `ST_STREAM` holds until reset, and every load in that state reloads the address.

Top module: `flash_addr_gen`

## Requirements
- R1: While reset is held and after its release, `array_addr` is 0 and `seg_rd_data` is 8'h00 if `seg_dflt_hi` is 0, or 8'h03 if it is 1.
- R2: A cycle with `seg_wr_en`=1 stores `seg_wr_data[1:0]` into the segment register. From the next cycle `seg_rd_data` = {6'b0, stored value}, and bits 7:2 always read 0.
- R3: A load with `addr4_mode`=0 gives `array_addr` = {segment[1:0], `cmd_addr[23:0]`} one cycle later. `cmd_addr[31:24]` has no effect.
- R4: A load with `addr4_mode`=1 gives `array_addr` = `cmd_addr[25:0]` one cycle later, whatever the segment register holds.
- R5: In `ST_STREAM`, an advance strobe without a load adds one to `array_addr`, including the step from the last byte of a segment (e.g. 26'h0FFFFFF) to the first byte of the next segment (26'h1000000).
- R6: An advance from 26'h3FFFFFF gives 26'h0000000.
- R7: A segment crossing or wrap by advance leaves `seg_rd_data` unchanged. The register changes only on a write.
- R8: When load and advance are both high in one cycle, the load wins and the new address is the loaded one, not incremented.
- R9: In `ST_IDLE` (no load since reset), advance strobes leave `array_addr` at 0.
- R10: With no load and no accepted advance, `array_addr` holds. A segment register write does not alter the current address, only later 3-byte loads.
- R11: `addr4_mode` may change at any time. It is sampled only on a load, so changing it between loads leaves `array_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| seg_dflt_hi | input | 1 | Reset default of segment register: 0 = segment 0, 1 = segment 3 |
| addr4_mode | input | 1 | 1 = 4-byte addressing, 0 = 3-byte addressing |
| load_stb | input | 1 | Start of command: load address from `cmd_addr` |
| adv_stb | input | 1 | Byte advance: increment address |
| cmd_addr | input | 32 | Address carried by the command |
| seg_wr_en | input | 1 | Write strobe for the segment register |
| seg_wr_data | input | 8 | Write data for the segment register |
| seg_rd_data | output | 8 | Segment register readback, bits 7:2 zero |
| array_addr | output | 26 | Current array byte address |

## Verification
Every result here is registered once. A load, advance or register write seen at one rising edge shows on `array_addr` or `seg_rd_data` right after that edge, and stays there until the next edge. The bench drives inputs at the falling edge. It updates its reference model from the inputs present at each rising edge, then compares both outputs one nanosecond after that edge, so each comparison sees exactly the one edge's effect. Directed segment crossings, the top-of-array wrap and load/advance collisions are mixed with seeded random traffic, and each cycle checks both outputs.

// File: rtl/flash_addr_pkg.sv
package flash_addr_pkg;
    parameter int ADDR_W    = 26;
    parameter int LOW_W     = 24;
    parameter int SEG_W     = ADDR_W - LOW_W;
    parameter int CMD_W     = 32;
    parameter int REG_W     = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } gen_state_t;
endpackage

// File: rtl/seg_select_reg.sv
module seg_select_reg
    import flash_addr_pkg::*;
#(
    parameter int SW = SEG_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dflt_hi,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output logic [SW-1:0] seg,
    output logic [RW-1:0] rd_data
);
    logic [SW-1:0] seg_q;

    // Reset value taken from the default-select pin: all zeros or all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg_q <= {SW{dflt_hi}};
        else if (wr_en)
            seg_q <= wr_data[SW-1:0];
    end

    assign seg     = seg_q;
    assign rd_data = {{(RW-SW){1'b0}}, seg_q};
endmodule

// File: rtl/gen_sequencer.sv
module gen_sequencer
    import flash_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_stb,
    input  logic adv_stb,
    output logic do_load,
    output logic do_adv
);
    gen_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load_stb) state_d = ST_STREAM;
            ST_STREAM: state_d = ST_STREAM;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: load always honoured; advance only while streaming
    // and only when no load is present in the same cycle.
    always_comb begin
        do_load = load_stb;
        do_adv  = 1'b0;
        unique case (state_q)
            ST_IDLE:   do_adv = 1'b0;
            ST_STREAM: do_adv = adv_stb && !load_stb;
            default:   do_adv = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_counter.sv
module addr_counter
    import flash_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LOW_W,
    parameter int CW = CMD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_load,
    input  logic          do_adv,
    input  logic          wide_mode,
    input  logic [CW-1:0] cmd_addr,
    input  logic [AW-LW-1:0] seg,
    output logic [AW-1:0] addr
);
    localparam int UW = AW - LW;

    logic [AW-1:0] addr_q;
    logic [AW-1:0] load_val;

    // Upper bits from the command in wide mode, from the segment otherwise.
    always_comb begin
        if (wide_mode)
            load_val = cmd_addr[AW-1:0];
        else
            load_val = {seg[UW-1:0], cmd_addr[LW-1:0]};
    end

    // Natural modulo-2^AW increment crosses segments and wraps at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (do_load)
            addr_q <= load_val;
        else if (do_adv)
            addr_q <= addr_q + {{(AW-1){1'b0}}, 1'b1};
    end

    assign addr = addr_q;
endmodule

// File: rtl/flash_addr_gen.sv
module flash_addr_gen
    import flash_addr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seg_dflt_hi,
    input  logic        addr4_mode,
    input  logic        load_stb,
    input  logic        adv_stb,
    input  logic [31:0] cmd_addr,
    input  logic        seg_wr_en,
    input  logic [7:0]  seg_wr_data,
    output logic [7:0]  seg_rd_data,
    output logic [25:0] array_addr
);
    logic [SEG_W-1:0] seg;
    logic             do_load;
    logic             do_adv;

    seg_select_reg #(.SW(SEG_W), .RW(REG_W)) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .dflt_hi (seg_dflt_hi),
        .wr_en   (seg_wr_en),
        .wr_data (seg_wr_data),
        .seg     (seg),
        .rd_data (seg_rd_data)
    );

    gen_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (load_stb),
        .adv_stb  (adv_stb),
        .do_load  (do_load),
        .do_adv   (do_adv)
    );

    addr_counter #(.AW(ADDR_W), .LW(LOW_W), .CW(CMD_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_load   (do_load),
        .do_adv    (do_adv),
        .wide_mode (addr4_mode),
        .cmd_addr  (cmd_addr),
        .seg       (seg),
        .addr      (array_addr)
    );
endmodule

// File: rtl/flash_addr_gen_chk.sv
module flash_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        addr4_mode,
    input logic        load_stb,
    input logic        adv_stb,
    input logic [31:0] cmd_addr,
    input logic        seg_wr_en,
    input logic [7:0]  seg_wr_data,
    input logic [7:0]  seg_rd_data,
    input logic [25:0] array_addr
);
    logic seen_load;

    always_ff @(posedge clk) begin
        if (!rst_n)        seen_load <= 1'b0;
        else if (load_stb) seen_load <= 1'b1;
    end

    a_r1_reset_addr: assert property (@(posedge clk)
        !rst_n |=> array_addr == 26'd0);

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        seg_rd_data[7:2] == 6'd0);

    a_r2_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
        seg_wr_en |=> seg_rd_data[1:0] == $past(seg_wr_data[1:0]));

    a_r3_short_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && !addr4_mode |=>
            array_addr == {$past(seg_rd_data[1:0]), $past(cmd_addr[23:0])});

    a_r4_wide_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb && addr4_mode |=> array_addr == $past(cmd_addr[25:0]));

    a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
        seen_load && adv_stb && !load_stb |=>
            array_addr == $past(array_addr) + 26'd1);

    a_r7_seg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_wr_en |=> $stable(seg_rd_data));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb && !(adv_stb && seen_load) |=> $stable(array_addr));
endmodule

bind flash_addr_gen flash_addr_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr4_mode  (addr4_mode),
    .load_stb    (load_stb),
    .adv_stb     (adv_stb),
    .cmd_addr    (cmd_addr),
    .seg_wr_en   (seg_wr_en),
    .seg_wr_data (seg_wr_data),
    .seg_rd_data (seg_rd_data),
    .array_addr  (array_addr)
);

// File: tb/flash_addr_gen_tb_top.sv
`timescale 1ns/1ps
module flash_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_dflt_hi = 1'b0;
    logic        addr4_mode = 1'b0;
    logic        load_stb = 1'b0;
    logic        adv_stb = 1'b0;
    logic [31:0] cmd_addr = 32'd0;
    logic        seg_wr_en = 1'b0;
    logic [7:0]  seg_wr_data = 8'd0;
    logic [7:0]  seg_rd_data;
    logic [25:0] array_addr;

    int total = 0;
    int bad   = 0;

    logic [25:0] m_addr;
    logic [1:0]  m_seg;
    logic        m_active;

    always #2 clk = ~clk;

    flash_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .seg_dflt_hi(seg_dflt_hi),
        .addr4_mode(addr4_mode), .load_stb(load_stb), .adv_stb(adv_stb),
        .cmd_addr(cmd_addr), .seg_wr_en(seg_wr_en), .seg_wr_data(seg_wr_data),
        .seg_rd_data(seg_rd_data), .array_addr(array_addr)
    );

    function automatic logic [25:0] load_addr(input logic wide, input logic [31:0] ca,
                                              input logic [1:0] sg);
        return wide ? ca[25:0] : {sg, ca[23:0]};
    endfunction

    task automatic check(input string tag);
        total++;
        if (array_addr !== m_addr) begin
            bad++;
            $display("FAIL %s addr actual=%h expected=%h", tag, array_addr, m_addr);
        end
        total++;
        if (seg_rd_data !== {6'd0, m_seg}) begin
            bad++;
            $display("FAIL %s seg actual=%h expected=%h", tag, seg_rd_data, {6'd0, m_seg});
        end
    endtask

    // One clock: inputs set at the falling edge before; model updated from them.
    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_addr = '0; m_seg = {2{seg_dflt_hi}}; m_active = 1'b0;
        end else begin
            if (load_stb) begin
                m_addr = load_addr(addr4_mode, cmd_addr, m_seg);
                m_active = 1'b1;
            end else if (adv_stb && m_active) begin
                m_addr = m_addr + 26'd1;
            end
            if (seg_wr_en) m_seg = seg_wr_data[1:0];
        end
        #1;
        check(tag);
        @(negedge clk);
        load_stb = 1'b0; adv_stb = 1'b0; seg_wr_en = 1'b0;
    endtask

    task automatic do_reset(input logic hi, input string tag);
        @(negedge clk);
        seg_dflt_hi = hi; rst_n = 1'b0;
        cyc(tag); cyc(tag);
        rst_n = 1'b1;
        cyc(tag);
    endtask

    task automatic ld(input logic wide, input logic [31:0] a, input string tag);
        addr4_mode = wide; cmd_addr = a; load_stb = 1'b1;
        cyc(tag);
    endtask

    task automatic wr(input logic [7:0] d, input string tag);
        seg_wr_data = d; seg_wr_en = 1'b1;
        cyc(tag);
    endtask

    task automatic adv(input string tag);
        adv_stb = 1'b1;
        cyc(tag);
    endtask

    initial begin
        m_addr = '0; m_seg = '0; m_active = 1'b0;
        void'($urandom(32'h5eed_1234));

        do_reset(1'b0, "R1");
        adv("R9"); adv("R9");
        do_reset(1'b1, "R1");
        adv("R9");

        wr(8'hFC, "R2");
        wr(8'hA5, "R2");
        ld(1'b0, 32'hEE12_3456, "R3");
        ld(1'b0, 32'h00FF_FFFE, "R3");
        adv("R5"); adv("R5");
        adv("R7");
        wr(8'h03, "R2");
        ld(1'b0, 32'h7700_FFFF - 32'h0000_0000, "R3");
        ld(1'b0, 32'h00FF_FFFF, "R3");
        adv("R6"); adv("R7");
        ld(1'b1, 32'hFFFF_FFFE, "R4");
        adv("R6"); adv("R6");
        wr(8'h02, "R10");
        cyc("R10");
        addr4_mode = 1'b0; cyc("R11");
        addr4_mode = 1'b1; cyc("R11");
        ld(1'b1, 32'h0155_5555, "R4");
        addr4_mode = 1'b0; cmd_addr = 32'h0012_3400; load_stb = 1'b1; adv_stb = 1'b1;
        cyc("R8");
        addr4_mode = 1'b1; cmd_addr = 32'h03FF_FFFF; load_stb = 1'b1; adv_stb = 1'b1;
        seg_wr_en = 1'b1; seg_wr_data = 8'h01;
        cyc("R8");
        adv("R6");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            addr4_mode  = r[0];
            load_stb    = (r[3:1] == 3'd0);
            adv_stb     = r[4] | r[5];
            seg_wr_en   = (r[8:6] == 3'd0);
            seg_wr_data = r[15:8];
            cmd_addr    = (r[9] ? {$urandom} : {6'd0, r[17:16], 24'hFFFFF0 | 24'(r[19:18])});
            cyc("R5");
        end

        do_reset(1'b0, "R1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule